// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block is a passive monitor that sits beside an I2C slave and decides which timing regime the bus is using. It brings the SCL and SDA lines into the system clock domain and finds the bus conditions on them: START, repeated START and STOP. It also reads the first byte after each plain START and the bit that follows it. When that byte is a reserved high-speed master code and the master leaves the following bit unacknowledged, the block raises `hs_mode`. The slave's own bit-level logic uses that level to select high-speed timing.

Once raised, `hs_mode` stays high through any number of repeated STARTs and the transfers that follow them. Only a STOP or a synchronous reset brings it back to Fast/Standard mode. A master code that some device acknowledges is a protocol error, and the bus stays in Fast/Standard mode. The block gives one-cycle pulses for each condition it finds and for each master code it recognises. It drives nothing onto the bus.

Top module: `i2c_hs_mode_detect`

## Requirements
- R1: SDA falling while SCL is high on an idle bus gives one `start_pulse` lasting one clock cycle.
- R2: SDA falling while SCL is high after a START and before the next STOP gives one `rstart_pulse` and no `start_pulse`.
- R3: SDA rising while SCL is high gives one `stop_pulse` and returns the bus to idle.
- R4: In any cycle, at most one of `start_pulse`, `rstart_pulse` and `stop_pulse` is high.
- R5: The first byte after a START is captured MSB first, one bit per SCL rising edge. If its bits 7 to 3 are 00001, whatever bits 2 to 0 hold, `mcode_pulse` is high for one cycle after the eighth rising edge.
- R6: A first byte whose bits 7 to 3 are not 00001 (for example 0x10, 0x07 or 0xF8) gives no `mcode_pulse` and leaves `hs_mode` low.
- R7: When SDA is high (NACK) on the ninth SCL rising edge after a master code, `hs_mode` rises.
- R8: When SDA is low (ACK) on the ninth SCL rising edge after a master code, the code is treated as a protocol error and `hs_mode` stays low.
- R9: `hs_mode` stays high across repeated STARTs and the bytes after them. A byte that matches 00001xxx after a repeated START is not a master code and gives no `mcode_pulse`.
- R10: A STOP clears `hs_mode` in the same cycle as `stop_pulse`. The next START begins in Fast/Standard mode.
- R11: While `rst` is high, every output is low. Asserting `rst` in high-speed mode clears `hs_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| hs_mode | output | 1 | High while the bus is in high-speed mode |
| start_pulse | output | 1 | One-cycle pulse on a START from idle |
| rstart_pulse | output | 1 | One-cycle pulse on a repeated START |
| stop_pulse | output | 1 | One-cycle pulse on a STOP |
| mcode_pulse | output | 1 | One-cycle pulse when a master code completes |

## Verification
Some properties are checked on every cycle: the bus-condition pulses are mutually exclusive; each START and repeated START agrees with the idle or busy state that came before it; `hs_mode` rises only from a NACK after a master code, is low whenever a STOP or a master code is reported, holds through repeated STARTs, and stays low after an acknowledged code. Other behaviour only the bench scenarios can show: that a byte is recognised as a master code regardless of its low three bits; that non-matching bytes and bytes after a repeated START are ignored; the exact order of events over whole transactions; and the clearing of high-speed mode by a reset in the middle of a transfer.

// File: rtl/i2c_hsd_pkg.sv
package i2c_hsd_pkg;

  localparam int BYTE_W      = 8;
  localparam int CNT_W       = $clog2(BYTE_W);
  localparam int MC_PREFIX_W = 5;
  localparam logic [MC_PREFIX_W-1:0] MC_PREFIX = 5'b00001;

  // Where the monitor stands within the current transfer
  typedef enum logic [1:0] {
    PH_IDLE,    // no transfer open
    PH_FIRST,   // collecting the byte that follows a plain START
    PH_MC_ACK,  // waiting for the bit after a master code
    PH_OTHER    // anything else while the bus is busy
  } phase_t;

  // A reserved high-speed code: the prefix is fixed, the low bits are free
  function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: MC_PREFIX_W] == MC_PREFIX;
  endfunction

  // Shift one received bit in, MSB first
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sh,
                                                 input logic bit_in);
    return {sh[BYTE_W-2:0], bit_in};
  endfunction

endpackage

// File: rtl/i2c_hsd_sync.sv
// Brings the asynchronous bus lines into the clock domain. For each line it
// gives the synchronised level and that level delayed by one more cycle.
module i2c_hsd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  generate
    for (genvar k = 0; k < W; k++) begin : g_line
      // stages 0..STAGES-1 synchronise; stage STAGES is the history tap
      logic [STAGES:0] chain;

      always_ff @(posedge clk) begin
        if (rst) chain <= '1;  // an idle bus is high
        else     chain <= {chain[STAGES-1:0], din[k]};
      end

      assign q[k]   = chain[STAGES-1];
      assign q_d[k] = chain[STAGES];
    end
  endgenerate

endmodule

// File: rtl/i2c_hsd_cond.sv
// Finds START, repeated START and STOP, and tracks whether the bus is busy.
module i2c_hsd_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic scl_d,
  input  logic sda_s,
  input  logic sda_d,
  output logic start_ev,
  output logic rstart_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic busy
);

  logic scl_steady_hi;
  logic start_raw;
  logic stop_raw;

  assign scl_steady_hi = scl_s & scl_d;
  assign start_raw     = scl_steady_hi & sda_d & ~sda_s;
  assign stop_raw      = scl_steady_hi & ~sda_d & sda_s;
  assign scl_rise      = scl_s & ~scl_d;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (stop_raw)  busy <= 1'b0;
    else if (start_raw) busy <= 1'b1;
  end

  assign start_ev  = start_raw & ~busy;
  assign rstart_ev = start_raw & busy;
  assign stop_ev   = stop_raw;

endmodule

// File: rtl/i2c_hsd_mode.sv
// Reads the byte after a plain START and decides on the bus mode.
module i2c_hsd_mode
  import i2c_hsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_ev,
  input  logic rstart_ev,
  input  logic stop_ev,
  input  logic scl_rise,
  input  logic sda_bit,
  output logic hs_mode,
  output logic mc_hit,
  output logic mc_nack,
  output logic mc_ack_err
);

  phase_t            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_now;
  logic              last_bit;
  logic              first_done;

  assign byte_now   = shift_in(shreg, sda_bit);
  assign last_bit   = bit_cnt == CNT_W'(BYTE_W - 1);
  assign first_done = (phase == PH_FIRST) & scl_rise & last_bit;
  assign mc_hit     = first_done & is_master_code(byte_now);
  assign mc_nack    = (phase == PH_MC_ACK) & scl_rise & sda_bit;
  assign mc_ack_err = (phase == PH_MC_ACK) & scl_rise & ~sda_bit;

  always_ff @(posedge clk) begin
    if (rst || stop_ev) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      hs_mode <= 1'b0;
    end else if (start_ev) begin
      phase   <= PH_FIRST;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (rstart_ev) begin
      // stay in the current mode; bytes after Sr are never master codes
      phase   <= PH_OTHER;
      bit_cnt <= '0;
    end else if (scl_rise) begin
      unique case (phase)
        PH_FIRST: begin
          shreg <= byte_now;
          if (last_bit) begin
            bit_cnt <= '0;
            phase   <= is_master_code(byte_now) ? PH_MC_ACK : PH_OTHER;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_MC_ACK: begin
          if (sda_bit) hs_mode <= 1'b1;
          phase <= PH_OTHER;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_hs_mode_detect.sv
module i2c_hs_mode_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic hs_mode,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse,
  output logic mcode_pulse
);

  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_d;

  // events between the pieces, named for the checker
  logic start_w;
  logic rstart_w;
  logic stop_w;
  logic scl_rise_w;
  logic busy_w;
  logic mc_hit_w;
  logic mc_nack_w;
  logic mc_ack_err_w;

  i2c_hsd_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sda_in, scl_in}),
    .q   (line_s),
    .q_d (line_d)
  );

  i2c_hsd_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (line_s[0]),
    .scl_d     (line_d[0]),
    .sda_s     (line_s[1]),
    .sda_d     (line_d[1]),
    .start_ev  (start_w),
    .rstart_ev (rstart_w),
    .stop_ev   (stop_w),
    .scl_rise  (scl_rise_w),
    .busy      (busy_w)
  );

  i2c_hsd_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .start_ev   (start_w),
    .rstart_ev  (rstart_w),
    .stop_ev    (stop_w),
    .scl_rise   (scl_rise_w),
    .sda_bit    (line_s[1]),
    .hs_mode    (hs_mode),
    .mc_hit     (mc_hit_w),
    .mc_nack    (mc_nack_w),
    .mc_ack_err (mc_ack_err_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
      mcode_pulse  <= 1'b0;
    end else begin
      start_pulse  <= start_w;
      rstart_pulse <= rstart_w;
      stop_pulse   <= stop_w;
      mcode_pulse  <= mc_hit_w;
    end
  end

endmodule

// File: rtl/i2c_hs_mode_detect_chk.sv
module i2c_hs_mode_detect_chk (
  input logic clk,
  input logic rst,
  input logic hs_mode,
  input logic start_pulse,
  input logic rstart_pulse,
  input logic stop_pulse,
  input logic mcode_pulse,
  input logic busy,
  input logic mc_nack,
  input logic mc_ack_err
);

  p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> !$past(busy));

  p_rstart_busy_r2: assert property (@(posedge clk) disable iff (rst)
    rstart_pulse |-> $past(busy));

  p_stop_idle_r3: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !busy);

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));

  p_mcode_fs_r5: assert property (@(posedge clk) disable iff (rst)
    mcode_pulse |-> !hs_mode);

  p_hs_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> $past(mc_nack));

  p_ack_no_hs_r8: assert property (@(posedge clk) disable iff (rst)
    mc_ack_err |=> !hs_mode);

  p_hs_keep_r9: assert property (@(posedge clk) disable iff (rst)
    rstart_pulse |-> hs_mode == $past(hs_mode));

  p_hs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    hs_mode |-> busy);

  p_stop_clear_r10: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !hs_mode);

endmodule

bind i2c_hs_mode_detect i2c_hs_mode_detect_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .hs_mode      (hs_mode),
  .start_pulse  (start_pulse),
  .rstart_pulse (rstart_pulse),
  .stop_pulse   (stop_pulse),
  .mcode_pulse  (mcode_pulse),
  .busy         (busy_w),
  .mc_nack      (mc_nack_w),
  .mc_ack_err   (mc_ack_err_w)
);

// File: tb/i2c_hs_mode_detect_tb.sv
module i2c_hs_mode_detect_tb;

  localparam int H        = 8;       // cycles per SCL half phase
  localparam int WATCHDOG = 150000;

  localparam int EV_START  = 0;
  localparam int EV_RSTART = 1;
  localparam int EV_STOP   = 2;
  localparam int EV_MCODE  = 3;
  localparam int EV_HS_ON  = 4;
  localparam int EV_HS_OFF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic hs_mode, start_pulse, rstart_pulse, stop_pulse, mcode_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];

  // bench's own view of the bus
  bit bm_busy = 0;
  bit bm_hs = 0;
  bit bm_first = 0;
  bit bm_mc = 0;

  always #10 clk = ~clk;

  i2c_hs_mode_detect u_dut (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .hs_mode      (hs_mode),
    .start_pulse  (start_pulse),
    .rstart_pulse (rstart_pulse),
    .stop_pulse   (stop_pulse),
    .mcode_pulse  (mcode_pulse)
  );

  function automatic string ev_tag(input int e);
    case (e)
      EV_START:  return "R1 start";
      EV_RSTART: return "R2 rstart";
      EV_STOP:   return "R3 stop";
      EV_MCODE:  return "R5 mcode";
      EV_HS_ON:  return "R7 hs_on";
      default:   return "R10 hs_off";
    endcase
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic got(input int e);
    int want;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual event %0d expected none (unexpected; R6/R9 if mcode)",
               ev_tag(e), e);
    end else begin
      want = exp_q.pop_front();
      if (want != e) begin
        errors++;
        $display("FAIL %s: actual event %0d expected event %0d", ev_tag(want), e, want);
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compares observed events with the scoreboard queue
  initial begin
    int npulse;
    bit prev_hs;
    prev_hs = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      npulse = int'(start_pulse) + int'(rstart_pulse) + int'(stop_pulse);
      if (npulse > 0) check_eq("R4 one condition pulse", npulse, 1);
      if (start_pulse)  got(EV_START);
      if (rstart_pulse) got(EV_RSTART);
      if (stop_pulse)   got(EV_STOP);
      if (mcode_pulse)  got(EV_MCODE);
      if (hs_mode !== prev_hs) got(hs_mode ? EV_HS_ON : EV_HS_OFF);
      prev_hs = hs_mode;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog R1: actual %0d cycles expected below %0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (bm_busy) begin
      exp_q.push_back(EV_RSTART);
      bm_first = 0;
    end else begin
      exp_q.push_back(EV_START);
      bm_first = 1;
    end
    bm_busy = 1;
    sda_in = 1'b1; wait_cyc(H);
    scl_in = 1'b1; wait_cyc(H);
    sda_in = 1'b0; wait_cyc(H);
    scl_in = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_bit(input bit b);
    sda_in = b;    wait_cyc(H);
    scl_in = 1'b1; wait_cyc(H);
    scl_in = 1'b0; wait_cyc(H);
  endtask

  task automatic bus_byte(input logic [7:0] b);
    // master code: value 8 to 15 inclusive
    if (bm_first && b >= 8'd8 && b <= 8'd15) begin
      exp_q.push_back(EV_MCODE);
      bm_mc = 1;
    end
    bm_first = 0;
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  task automatic bus_ack(input bit nack);
    if (bm_mc && nack) begin
      exp_q.push_back(EV_HS_ON);
      bm_hs = 1;
    end
    bm_mc = 0;
    bus_bit(nack);
  endtask

  task automatic bus_stop();
    exp_q.push_back(EV_STOP);
    if (bm_hs) exp_q.push_back(EV_HS_OFF);
    bm_hs = 0;
    bm_busy = 0;
    sda_in = 1'b0; wait_cyc(H);
    scl_in = 1'b1; wait_cyc(H);
    sda_in = 1'b1; wait_cyc(H);
  endtask

  initial begin
    wait_cyc(4);
    // R11: outputs low during reset
    check_eq("R11 hs_mode in reset", int'(hs_mode), 0);
    check_eq("R11 pulses in reset",
             int'(start_pulse | rstart_pulse | stop_pulse | mcode_pulse), 0);
    rst = 1'b0;
    wait_cyc(5);

    // R5, R7: master code 0x08 with NACK enters high-speed mode
    bus_start();
    bus_byte(8'h08);
    bus_ack(1'b1);
    check_eq("R7 hs after NACK", int'(hs_mode), 1);

    // R9: repeated STARTs keep the mode; 0x0F after Sr is not a master code
    bus_start();
    bus_byte(8'h0F);
    bus_ack(1'b0);
    bus_byte(8'h55);
    bus_ack(1'b0);
    bus_start();
    bus_byte(8'hA1);
    bus_ack(1'b1);
    check_eq("R9 hs kept after repeated START", int'(hs_mode), 1);

    // R10: STOP clears the mode
    bus_stop();
    check_eq("R10 hs cleared by STOP", int'(hs_mode), 0);

    // R8: acknowledged master code does not enter high-speed mode
    bus_start();
    bus_byte(8'h0D);
    bus_ack(1'b0);
    check_eq("R8 hs after ACKed code", int'(hs_mode), 0);
    bus_stop();

    // R6: non-matching first bytes
    bus_start();
    bus_byte(8'h10);
    bus_ack(1'b1);
    check_eq("R6 hs after 0x10", int'(hs_mode), 0);
    bus_stop();
    bus_start();
    bus_byte(8'h07);
    bus_ack(1'b1);
    check_eq("R6 hs after 0x07", int'(hs_mode), 0);
    bus_stop();
    bus_start();
    bus_byte(8'hF8);
    bus_ack(1'b1);
    check_eq("R6 hs after 0xF8", int'(hs_mode), 0);
    bus_stop();

    // R5: low three bits are don't-care (0x0F), then R10 next START is F/S
    bus_start();
    bus_byte(8'h0F);
    bus_ack(1'b1);
    check_eq("R5 hs after 0x0F", int'(hs_mode), 1);
    bus_stop();
    bus_start();
    check_eq("R10 new START in F/S", int'(hs_mode), 0);
    bus_byte(8'h0A);
    bus_ack(1'b1);
    check_eq("R7 hs after 0x0A NACK", int'(hs_mode), 1);

    // R11: reset in high-speed mode clears it
    exp_q.push_back(EV_HS_OFF);
    bm_hs = 0;
    bm_busy = 0;
    rst = 1'b1;
    wait_cyc(3);
    check_eq("R11 hs cleared by reset", int'(hs_mode), 0);
    rst = 1'b0;
    wait_cyc(5);
    bus_stop();
    check_eq("R11 hs after reset and STOP", int'(hs_mode), 0);

    wait_cyc(10);
    if (exp_q.size() != 0)
      check_eq(ev_tag(exp_q[0]), 0, exp_q.size());
    else
      check_eq("R3 all expected events seen", 0, 0);
    finish_run();
  end

endmodule